// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesizer

This block produces the phase of a colour subcarrier with a 32-bit phase accumulator clocked by the pixel clock. On every cycle the accumulator adds a tuning word and wraps modulo 2^32. The top bits of the phase, plus a programmable phase offset, address a quarter-wave sine table, and the block drives both a sine and a cosine sample from it.

The tuning word is loaded by software in four byte writes, byte 0 first and byte 3 last. Bytes 0 to 2 are held in a shadow store. The running frequency does not move until byte 3 arrives. Then the whole word replaces the active one in a single clock, so the accumulator never steps with a half-written word. A synchronous clear input returns the accumulator to zero without touching the tuning word, and reset loads the NTSC word.

Top module: `subcarrier_dds`

## Requirements
- R1: While `rst_n` is low, and after it is released, `phase_o` is 0 and the active tuning word is 0x21F07C1F, so the first step after release is 0x21F07C1F.
- R2: On each rising clock edge with `phase_clr` low, `phase_o` becomes its previous value plus the active tuning word of that cycle.
- R3: A write with `wr_idx` of 0, 1 or 2 leaves the running frequency unchanged. The step of `phase_o` stays at the previous word.
- R4: A write with `wr_idx` = 3 replaces the active word with {`wr_data`, shadow byte 2, shadow byte 1, shadow byte 0} at that edge. The accumulation at that same edge still uses the old word, and the new word applies from the next edge.
- R5: Writing 0xCB, 0x8A, 0x09 and 0x2A to indices 0, 1, 2 and 3, in that order, gives a step of 0x2A098ACB.
- R6: When `phase_clr` is high at an edge, `phase_o` becomes 0 whatever the accumulation would give. The tuning word is kept.
- R7: Byte index k holds bits 8k+7 down to 8k of the word. A byte-3 write that has no earlier writes to indices 0 to 2 reuses the shadow bytes that reset or earlier writes left.
- R8: The table address is a = (`phase_o`[31:24] + `phase_ofs`) mod 256. `sin_o` is (511*h*(128-h)+2048)/4096 with h = a mod 128, integer division, and is negated when a >= 128.
- R9: `cos_o` equals the `sin_o` function at address (a + 64) mod 256.
- R10: The accumulator wraps modulo 2^32. A step that passes 0xFFFFFFFF gives the low 32 bits of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clr | input | 1 | Synchronous accumulator clear |
| wr_en | input | 1 | Tuning byte write strobe |
| wr_idx | input | 2 | Index of the tuning byte being written |
| wr_data | input | 8 | Tuning byte value |
| phase_ofs | input | 8 | Phase offset added to the table address |
| phase_o | output | 32 | Accumulated phase |
| sin_o | output | 10 | Signed sine sample |
| cos_o | output | 10 | Signed cosine sample |

## Verification
The accumulator runs with the reset word, with the PAL word written in order, and with words of a single set bit in the table-address range. The first two tell whether each byte lands in its own bit position. The third walks the table one address per clock, so every quadrant mirror and sign flip of sine and cosine is checked. A partial load followed by a measured step shows whether bytes leak before commit. A lone byte-3 write shows that the shadow is reused. A large word shows that the accumulator wraps, and clear pulses show that clear takes priority and that the word survives them.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;

   // Magnitude of one quarter-wave entry: parabolic fit of sin over k in [0, q].
   function automatic int quarter_mag(input int k, input int q, input int amp);
      return (amp * k * (2 * q - k) + (q * q) / 2) / (q * q);
   endfunction

   typedef enum logic [1:0] {
      QD_RISE  = 2'b00,
      QD_FALL  = 2'b01,
      QD_NRISE = 2'b10,
      QD_NFALL = 2'b11
   } quad_e;

endpackage

// File: rtl/sc_tuning_regs.sv
module sc_tuning_regs #(
   parameter int          WORD_W     = 32,
   parameter int          BYTE_W     = 8,
   parameter logic [31:0] RESET_WORD = 32'h21F07C1F,
   localparam int         NBYTES     = WORD_W / BYTE_W,
   localparam int         IDX_W      = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [WORD_W-1:0] word_o
);
   localparam int SHADOW_W = WORD_W - BYTE_W;
   localparam logic [WORD_W-1:0] RST_W = RESET_WORD[WORD_W-1:0];

   logic [SHADOW_W-1:0] shadow_q;
   logic                commit;

   assign commit = wr_en && (wr_idx == IDX_W'(NBYTES - 1));

   for (genvar b = 0; b < NBYTES - 1; b++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow_q[b*BYTE_W +: BYTE_W] <= RST_W[b*BYTE_W +: BYTE_W];
         else if (wr_en && (wr_idx == IDX_W'(b)))
            shadow_q[b*BYTE_W +: BYTE_W] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_o <= RST_W;
      else if (commit)
         word_o <= {wr_data, shadow_q};
   end
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [ACC_W-1:0] step,
   output logic [ACC_W-1:0] acc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_o <= '0;
      else if (clr)
         acc_o <= '0;
      else
         acc_o <= acc_o + step;
   end
endmodule

// File: rtl/sc_quarter_lut.sv
module sc_quarter_lut
   import sc_dds_pkg::*;
#(
   parameter int LUT_AW = 6,
   parameter int OUT_W  = 10,
   localparam int ADDR_W = LUT_AW + 2,
   localparam int Q      = 1 << LUT_AW,
   localparam int AMP    = (1 << (OUT_W - 1)) - 1
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic signed [OUT_W-1:0] val_o
);
   logic [OUT_W-2:0]  tbl [0:Q];
   logic [LUT_AW-1:0] fine;
   logic [LUT_AW:0]   idx;
   quad_e             quad;
   logic [OUT_W-1:0]  mag;

   for (genvar k = 0; k <= Q; k++) begin : g_tbl
      assign tbl[k] = (OUT_W-1)'(quarter_mag(k, Q, AMP));
   end

   assign fine = addr[LUT_AW-1:0];
   assign quad = quad_e'(addr[ADDR_W-1 -: 2]);

   always_comb begin
      case (quad)
         QD_FALL, QD_NFALL: idx = (LUT_AW+1)'(Q) - {1'b0, fine};
         default:           idx = {1'b0, fine};
      endcase
      mag = {1'b0, tbl[idx]};
      if (quad == QD_NRISE || quad == QD_NFALL)
         val_o = -$signed(mag);
      else
         val_o = $signed(mag);
   end
endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds #(
   parameter int          ACC_W      = 32,
   parameter int          BYTE_W     = 8,
   parameter int          LUT_AW     = 6,
   parameter int          OUT_W      = 10,
   parameter logic [31:0] RESET_WORD = 32'h21F07C1F,
   localparam int         NBYTES     = ACC_W / BYTE_W,
   localparam int         IDX_W      = $clog2(NBYTES),
   localparam int         ADDR_W     = LUT_AW + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    phase_clr,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [BYTE_W-1:0]       wr_data,
   input  logic [ADDR_W-1:0]       phase_ofs,
   output logic [ACC_W-1:0]        phase_o,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o
);
   localparam int Q = 1 << LUT_AW;

   if (ACC_W % BYTE_W != 0) begin : g_bad_bytes
      $error("ACC_W must be a whole number of bytes");
   end
   if (NBYTES < 2) begin : g_bad_count
      $error("tuning word needs at least two bytes");
   end
   if (ADDR_W > ACC_W) begin : g_bad_addr
      $error("table address wider than accumulator");
   end
   if (OUT_W < 3 || ACC_W > 32) begin : g_bad_out
      $error("unsupported output or accumulator width");
   end

   logic [ACC_W-1:0]  tune_word;
   logic [ADDR_W-1:0] base_addr;
   logic signed [OUT_W-1:0] lut_val [2];

   sc_tuning_regs #(
      .WORD_W(ACC_W), .BYTE_W(BYTE_W), .RESET_WORD(RESET_WORD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .word_o(tune_word)
   );

   sc_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr),
      .step(tune_word), .acc_o(phase_o)
   );

   assign base_addr = phase_o[ACC_W-1 -: ADDR_W] + phase_ofs;

   // g=0 sine, g=1 cosine (a quarter turn ahead)
   for (genvar g = 0; g < 2; g++) begin : g_lut
      logic [ADDR_W-1:0] a;
      assign a = base_addr + ADDR_W'(g * Q);
      sc_quarter_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut (
         .addr(a), .val_o(lut_val[g])
      );
   end

   assign sin_o = lut_val[0];
   assign cos_o = lut_val[1];
endmodule

// File: rtl/sc_dds_checker.sv
module sc_dds_checker #(
   parameter int ACC_W  = 32,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 2,
   parameter int OUT_W  = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    phase_clr,
   input logic                    wr_en,
   input logic [IDX_W-1:0]        wr_idx,
   input logic [BYTE_W-1:0]       wr_data,
   input logic [ACC_W-1:0]        phase_o,
   input logic [ACC_W-1:0]        tune_word,
   input logic signed [OUT_W-1:0] sin_o,
   input logic signed [OUT_W-1:0] cos_o
);
   localparam int AMP = (1 << (OUT_W - 1)) - 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'((ACC_W / BYTE_W) - 1);

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> phase_o == '0); // R6

   AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_clr |=> phase_o == $past(phase_o) + $past(tune_word)); // R2

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == LAST) |=> $stable(tune_word)); // R3

   AST_WORD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == LAST) |=> tune_word[ACC_W-1 -: BYTE_W] == $past(wr_data)); // R4

   AST_SIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_o <= AMP) && (sin_o >= -AMP) && (cos_o <= AMP) && (cos_o >= -AMP)); // R8
endmodule

bind subcarrier_dds sc_dds_checker #(
   .ACC_W(ACC_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase_clr(phase_clr), .wr_en(wr_en),
   .wr_idx(wr_idx), .wr_data(wr_data), .phase_o(phase_o),
   .tune_word(tune_word), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/subcarrier_dds_tb.sv
module subcarrier_dds_tb;
   logic              clk = 1'b0;
   logic              rst_n;
   logic              phase_clr;
   logic              wr_en;
   logic [1:0]        wr_idx;
   logic [7:0]        wr_data;
   logic [7:0]        phase_ofs;
   logic [31:0]       phase_o;
   logic signed [9:0] sin_o;
   logic signed [9:0] cos_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_acc, m_word;
   logic [7:0]  m_sh [3];

   always #2 clk = ~clk;

   subcarrier_dds u_dut (
      .clk(clk), .rst_n(rst_n), .phase_clr(phase_clr), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .phase_ofs(phase_ofs),
      .phase_o(phase_o), .sin_o(sin_o), .cos_o(cos_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 32'h0;
         m_word = 32'h21F07C1F;
         m_sh[0] = 8'h1F; m_sh[1] = 8'h7C; m_sh[2] = 8'hF0;
      end else begin
         m_acc = phase_clr ? 32'h0 : m_acc + m_word;
         if (wr_en) begin
            if (wr_idx == 2'd3) m_word = {wr_data, m_sh[2], m_sh[1], m_sh[0]};
            else m_sh[wr_idx] = wr_data;
         end
      end
   end

   function automatic int ref_wave(input int a);
      int h, mag;
      h = a % 128;
      mag = (511 * h * (128 - h) + 2048) / 4096;
      return (a >= 128) ? -mag : mag;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare all outputs with the model, then advance one cycle
   task automatic cyc();
      int a;
      @(negedge clk);
      a = (int'(m_acc[31:24]) + int'(phase_ofs)) % 256;
      chk(phase_o == m_acc, "R2", phase_o, m_acc);
      chk(int'(sin_o) == ref_wave(a), "R8", sin_o, ref_wave(a));
      chk(int'(cos_o) == ref_wave((a + 64) % 256), "R9", cos_o, ref_wave((a + 64) % 256));
   endtask

   task automatic wr(input logic [1:0] i, input logic [7:0] d);
      wr_en = 1'b1; wr_idx = i; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic step_check(input string req, input logic [31:0] exp);
      logic [31:0] p0;
      p0 = phase_o;
      cyc();
      chk(phase_o - p0 == exp, req, phase_o - p0, exp);
   endtask

   task automatic set_word(input logic [31:0] w);
      wr(2'd0, w[7:0]); wr(2'd1, w[15:8]); wr(2'd2, w[23:16]); wr(2'd3, w[31:24]);
   endtask

   initial begin
      rst_n = 1'b0; phase_clr = 1'b0; wr_en = 1'b0; wr_idx = 2'd0;
      wr_data = 8'h0; phase_ofs = 8'h0;
      repeat (3) @(negedge clk);
      chk(phase_o == 32'h0, "R1", phase_o, 0);
      wr_en = 1'b1; wr_idx = 2'd3; wr_data = 8'h55;   // ignored under reset
      @(negedge clk);
      chk(phase_o == 32'h0, "R1", phase_o, 0);
      wr_en = 1'b0;
      rst_n = 1'b1;
      cyc();
      chk(phase_o == 32'h21F07C1F, "R1", phase_o, 32'h21F07C1F);
      step_check("R1", 32'h21F07C1F);
      repeat (5) cyc();

      // R3: partial PAL load leaves the step unchanged
      wr(2'd0, 8'hCB); wr(2'd1, 8'h8A); wr(2'd2, 8'h09);
      step_check("R3", 32'h21F07C1F);
      step_check("R3", 32'h21F07C1F);
      // R4: commit edge still uses old word
      begin
         logic [31:0] p0;
         p0 = phase_o;
         wr(2'd3, 8'h2A);
         chk(phase_o - p0 == 32'h21F07C1F, "R4", phase_o - p0, 32'h21F07C1F);
      end
      step_check("R5", 32'h2A098ACB);
      repeat (10) cyc();

      // R7: lone byte-3 write reuses shadow bytes
      wr(2'd3, 8'h10);
      step_check("R7", 32'h10098ACB);

      // R6: clear wins and keeps the word
      phase_clr = 1'b1;
      cyc();
      phase_clr = 1'b0;
      chk(phase_o == 32'h0, "R6", phase_o, 0);
      step_check("R6", 32'h10098ACB);
      phase_clr = 1'b1; wr_en = 1'b1; wr_idx = 2'd1; wr_data = 8'h77;
      cyc();
      phase_clr = 1'b0; wr_en = 1'b0;
      chk(phase_o == 32'h0, "R6", phase_o, 0);

      // R8/R9: walk every table address with several offsets
      set_word(32'h01000000);
      phase_clr = 1'b1; cyc(); phase_clr = 1'b0;
      for (int o = 0; o < 4; o++) begin
         phase_ofs = 8'(o * 37);
         repeat (256) cyc();
      end
      chk(sin_o != 0 || cos_o != 0, "R8", sin_o, 1);

      // R10: wrap
      set_word(32'hF0000001);
      phase_clr = 1'b1; cyc(); phase_clr = 1'b0;
      cyc();
      chk(phase_o == 32'hF0000001, "R10", phase_o, 32'hF0000001);
      cyc();
      chk(phase_o == 32'hE0000002, "R10", phase_o, 32'hE0000002);
      repeat (40) cyc();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule